// File: doc/BRIEF.md
# Streaming Line Prefetcher with Demand Throttle

This block watches the load addresses that leave an early pipeline stage and spots loads that walk through memory one 64-byte line at a time, upward or downward. A small table follows up to four such streams. Once a stream is confirmed, every new load that advances it queues a speculative request for the next line in the stream's direction.

Demand loads and speculative requests share one lookup port into the shared second-level cache. A demand load always takes the port. A queued prefetch uses the port only in a cycle with no demand load, and only while the count of outstanding demand requests is at or below a watermark. When the cache reports that a prefetch lookup missed, the block issues an external memory request for that line. Prefetch hits and all demand responses produce no memory traffic. The cache arrays and the memory controller sit outside the block.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, `lk_req_valid` and `mem_req_valid` are both 0 until a load or a cache response arrives.
- R2: A load with `ld_valid`=1 appears on the lookup port on the next cycle with `lk_req_valid`=1, `lk_req_pf`=0 (0 marks demand, 1 marks prefetch), and `lk_req_addr` equal to the load address unchanged.
- R3: A load to line L followed by a load to line L+1 (line = address bits above bit 5) confirms an upward stream. In the first following cycle with no load, a prefetch lookup (`lk_req_pf`=1) is issued for line L+2, at address (L+2)*64. A lone load never causes a prefetch.
- R4: A load to line L followed by a load to line L-1 confirms a downward stream, and the prefetch that follows targets line L-2.
- R5: Each later load that steps a confirmed stream to line M queues exactly one prefetch for the line one step beyond M in the stream's direction. A repeated load to the stream's current line queues none.
- R6: While `ld_valid`=1, no prefetch is issued. A queued prefetch goes out in the first cycle without a load and is not lost.
- R7: No prefetch is issued while `dem_pending` is greater than the watermark (default 4). A prefetch is allowed when `dem_pending` equals the watermark, and a queued prefetch goes out once the count drops back to it.
- R8: A cache response with `lk_rsp_valid`=1, `lk_rsp_pf`=1 and `lk_rsp_hit`=0 causes `mem_req_valid`=1 with `mem_req_addr` = `lk_rsp_addr` on the next cycle. A response that hits, or that belongs to a demand lookup, leaves `mem_req_valid`=0.
- R9: The table holds four streams. A load that matches no stream replaces an empty entry if one exists, otherwise the least recently used entry. Any load that matches an entry, including a repeat of its current line, makes that entry most recently used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Early-stage load address valid |
| ld_addr | input | 32 | Load byte address |
| dem_pending | input | 4 | Number of outstanding demand requests |
| lk_req_valid | output | 1 | Cache lookup request valid |
| lk_req_pf | output | 1 | 1 = prefetch lookup, 0 = demand lookup |
| lk_req_addr | output | 32 | Lookup address |
| lk_rsp_valid | input | 1 | Cache lookup response valid |
| lk_rsp_pf | input | 1 | Response belongs to a prefetch lookup |
| lk_rsp_hit | input | 1 | Lookup hit in the shared cache |
| lk_rsp_addr | input | 32 | Address of the responded lookup |
| mem_req_valid | output | 1 | External memory request valid |
| mem_req_addr | output | 32 | External memory request line address |

## Verification
Two functions can land in the same cycle: a new demand load and the issue of a prefetch that is already queued. Both want the single lookup port. The bench confirms a stream and then presents an unrelated load back to back. It expects a demand lookup, with `lk_req_pf`=0, in the cycle where the prefetch could have gone, and then the deferred prefetch at the right line in the first idle cycle. The demand-count throttle is tested on the same kind of queued prefetch: the count is held one above the watermark for several cycles, and the prefetch must appear exactly one cycle after the count falls back to the watermark.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/spf_stream_table.sv
module spf_stream_table
  import spf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ld_valid,
  input  logic [LINE_W-1:0]               ld_line,
  input  logic [ENTRIES-1:0]              grant,
  output logic [ENTRIES-1:0]              pend,
  output logic [ENTRIES-1:0][LINE_W-1:0]  tgt
);
  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             vld, conf;
  dir_e                           dir   [ENTRIES];
  logic [ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [AGE_W-1:0]               age   [ENTRIES];

  logic [ENTRIES-1:0] m_same, m_up, m_dn, m_any;
  logic [AGE_W-1:0]   hit_idx, vic_idx, idx;
  logic               any_hit, has_free, adj_sel, up_sel;

  // Match logic: a confirmed stream only follows its own direction
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_same[i] = vld[i] && (ld_line == line_q[i]);
      m_up[i]   = vld[i] && (ld_line == line_q[i] + LINE_W'(1)) &&
                  (!conf[i] || dir[i] == DIR_UP);
      m_dn[i]   = vld[i] && (ld_line == line_q[i] - LINE_W'(1)) &&
                  (!conf[i] || dir[i] == DIR_DN);
      m_any[i]  = m_same[i] | m_up[i] | m_dn[i];
    end
  end

  // Lowest-index hit, and the replacement victim
  always_comb begin
    hit_idx  = '0;
    any_hit  = 1'b0;
    vic_idx  = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m_any[i]) begin
        hit_idx = AGE_W'(i);
        any_hit = 1'b1;
      end
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!has_free && age[i] == AGE_W'(ENTRIES - 1)) vic_idx = AGE_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        vic_idx  = AGE_W'(i);
        has_free = 1'b1;
      end
    end
    idx     = any_hit ? hit_idx : vic_idx;
    adj_sel = any_hit && (m_up[hit_idx] || m_dn[hit_idx]);
    up_sel  = m_up[hit_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      conf <= '0;
      pend <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        dir[i]    <= DIR_UP;
        line_q[i] <= '0;
        tgt[i]    <= '0;
        age[i]    <= AGE_W'(i);
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (grant[i]) pend[i] <= 1'b0;
      end
      if (ld_valid) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (AGE_W'(j) == idx)       age[j] <= '0;
          else if (age[j] < age[idx]) age[j] <= age[j] + AGE_W'(1);
        end
        if (!any_hit) begin
          vld[idx]    <= 1'b1;
          conf[idx]   <= 1'b0;
          line_q[idx] <= ld_line;
          pend[idx]   <= 1'b0;
        end else if (adj_sel) begin
          conf[idx]   <= 1'b1;
          dir[idx]    <= up_sel ? DIR_UP : DIR_DN;
          line_q[idx] <= ld_line;
          pend[idx]   <= 1'b1;
          tgt[idx]    <= up_sel ? ld_line + LINE_W'(1) : ld_line - LINE_W'(1);
        end
      end
    end
  end

  // Checks
  logic [ENTRIES-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < ENTRIES; i++) age_seen[age[i]] = 1'b1;
  end

  a_r9_lru_permutation: assert property (@(posedge clk) disable iff (rst)
    age_seen == {ENTRIES{1'b1}});
  a_r9_touch_mru: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> age[$past(idx)] == '0);
  a_r5_step_queues: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && adj_sel) |=> pend[$past(idx)]);
  a_r3_alloc_quiet: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !any_hit) |=> !pend[$past(idx)]);
endmodule

// File: rtl/spf_issue_arb.sv
module spf_issue_arb #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int OFF     = 6,
  parameter int CNT_W   = 4,
  parameter int WMARK   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  ld_valid,
  input  logic [ADDR_W-1:0]                     ld_addr,
  input  logic [CNT_W-1:0]                      dem_pending,
  input  logic [ENTRIES-1:0]                    pend,
  input  logic [ENTRIES-1:0][ADDR_W-OFF-1:0]    tgt,
  output logic [ENTRIES-1:0]                    grant,
  output logic                                  lk_req_valid,
  output logic                                  lk_req_pf,
  output logic [ADDR_W-1:0]                     lk_req_addr
);
  localparam int LINE_W = ADDR_W - OFF;
  localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [SEL_W-1:0] sel;
  logic             any_pend, throttled, pf_go;

  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel      = SEL_W'(i);
        any_pend = 1'b1;
      end
    end
    throttled = dem_pending > CNT_W'(WMARK);
    pf_go     = any_pend && !ld_valid && !throttled;
    grant     = '0;
    if (pf_go) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_req_valid <= 1'b0;
      lk_req_pf    <= 1'b0;
      lk_req_addr  <= '0;
    end else if (ld_valid) begin
      lk_req_valid <= 1'b1;
      lk_req_pf    <= 1'b0;
      lk_req_addr  <= ld_addr;
    end else if (pf_go) begin
      lk_req_valid <= 1'b1;
      lk_req_pf    <= 1'b1;
      lk_req_addr  <= {tgt[sel], {OFF{1'b0}}};
    end else begin
      lk_req_valid <= 1'b0;
      lk_req_pf    <= 1'b0;
    end
  end

  a_r6_demand_wins: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> lk_req_valid && !lk_req_pf && lk_req_addr == $past(ld_addr));
  a_r7_throttle: assert property (@(posedge clk) disable iff (rst)
    (dem_pending > CNT_W'(WMARK)) |=> !(lk_req_valid && lk_req_pf));
  a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  a_r3_pf_aligned: assert property (@(posedge clk) disable iff (rst)
    (lk_req_valid && lk_req_pf) |-> lk_req_addr[OFF-1:0] == '0);
  initial begin
    assert (LINE_W > 1);
  end
endmodule

// File: rtl/spf_miss_filter.sv
module spf_miss_filter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic              rsp_pf,
  input  logic              rsp_hit,
  input  logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      mem_req_valid <= rsp_valid && rsp_pf && !rsp_hit;
      if (rsp_valid && rsp_pf && !rsp_hit) mem_req_addr <= rsp_addr;
    end
  end

  a_r8_miss_goes_out: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_pf && !rsp_hit) |=> mem_req_valid && mem_req_addr == $past(rsp_addr));
  a_r8_hit_stays: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |=> !mem_req_valid);
  a_r8_demand_stays: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_pf) |=> !mem_req_valid);
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 4,
  parameter int WMARK      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  dem_pending,
  output logic              lk_req_valid,
  output logic              lk_req_pf,
  output logic [ADDR_W-1:0] lk_req_addr,
  input  logic              lk_rsp_valid,
  input  logic              lk_rsp_pf,
  input  logic              lk_rsp_hit,
  input  logic [ADDR_W-1:0] lk_rsp_addr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);
  localparam int OFF    = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF;

  logic [ENTRIES-1:0]             pend, grant;
  logic [ENTRIES-1:0][LINE_W-1:0] tgt;

  spf_stream_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_table (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_line(ld_addr[ADDR_W-1:OFF]),
    .grant(grant), .pend(pend), .tgt(tgt)
  );

  spf_issue_arb #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFF(OFF),
                  .CNT_W(CNT_W), .WMARK(WMARK)) u_arb (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .dem_pending(dem_pending), .pend(pend), .tgt(tgt), .grant(grant),
    .lk_req_valid(lk_req_valid), .lk_req_pf(lk_req_pf), .lk_req_addr(lk_req_addr)
  );

  spf_miss_filter #(.ADDR_W(ADDR_W)) u_miss (
    .clk(clk), .rst(rst), .rsp_valid(lk_rsp_valid), .rsp_pf(lk_rsp_pf),
    .rsp_hit(lk_rsp_hit), .rsp_addr(lk_rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_req_valid && !mem_req_valid);
endmodule

// File: tb/stream_prefetch_bench.sv
module stream_prefetch_bench;
  localparam int WM = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [3:0]  dem_pending = '0;
  logic        lk_req_valid, lk_req_pf;
  logic [31:0] lk_req_addr;
  logic        lk_rsp_valid = 1'b0, lk_rsp_pf = 1'b0, lk_rsp_hit = 1'b0;
  logic [31:0] lk_rsp_addr = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  stream_prefetch u_stream_prefetch (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .dem_pending(dem_pending), .lk_req_valid(lk_req_valid), .lk_req_pf(lk_req_pf),
    .lk_req_addr(lk_req_addr), .lk_rsp_valid(lk_rsp_valid), .lk_rsp_pf(lk_rsp_pf),
    .lk_rsp_hit(lk_rsp_hit), .lk_rsp_addr(lk_rsp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_valid = 1'b0; dem_pending = '0; lk_rsp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Present a load for one edge; returns at the negedge after it
  task automatic load_line(input logic [25:0] ln, input logic [5:0] off);
    ld_valid = 1'b1;
    ld_addr  = {ln, off};
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic expect_demand(input logic [25:0] ln, input logic [5:0] off, input string tag);
    check({lk_req_valid, lk_req_pf, lk_req_addr}, {2'b10, ln, off}, {tag, " demand lookup"});
  endtask

  task automatic idle_expect_pf(input logic [25:0] ln, input string tag);
    @(negedge clk);
    check({lk_req_valid, lk_req_pf, lk_req_addr}, {2'b11, ln, 6'd0}, {tag, " prefetch lookup"});
  endtask

  task automatic idle_expect_none(input string tag);
    @(negedge clk);
    check({63'd0, lk_req_valid}, 64'd0, {tag, " no lookup"});
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check({62'd0, lk_req_valid, mem_req_valid}, 64'd0, "R1 outputs idle after reset");
  endtask

  task automatic t_demand();
    do_reset();
    load_line(26'h048D159, 6'h38);
    expect_demand(26'h048D159, 6'h38, "R2");
    idle_expect_none("R3 lone load");
  endtask

  task automatic t_up();
    do_reset();
    load_line(26'h100, 6'h04);
    load_line(26'h101, 6'h10);
    expect_demand(26'h101, 6'h10, "R2 second");
    idle_expect_pf(26'h102, "R3");
    idle_expect_none("R3 single prefetch");
  endtask

  task automatic t_down();
    do_reset();
    load_line(26'h200, 6'h00);
    load_line(26'h1FF, 6'h3F);
    idle_expect_pf(26'h1FE, "R4");
  endtask

  task automatic t_continue();
    do_reset();
    load_line(26'h300, 6'h0);
    load_line(26'h301, 6'h0);
    idle_expect_pf(26'h302, "R5 first");
    load_line(26'h302, 6'h8);
    idle_expect_pf(26'h303, "R5 step");
    load_line(26'h302, 6'h20);
    idle_expect_none("R5 repeat line");
  endtask

  task automatic t_priority();
    do_reset();
    load_line(26'h400, 6'h0);
    load_line(26'h401, 6'h0);
    load_line(26'h900, 6'h0);
    expect_demand(26'h900, 6'h0, "R6 demand beats prefetch");
    idle_expect_pf(26'h402, "R6 deferred");
  endtask

  task automatic t_throttle();
    do_reset();
    dem_pending = 4'(WM + 1);
    load_line(26'h500, 6'h0);
    load_line(26'h501, 6'h0);
    repeat (3) idle_expect_none("R7 above watermark");
    dem_pending = 4'(WM);
    idle_expect_pf(26'h502, "R7 at watermark");
    dem_pending = '0;
  endtask

  task automatic t_miss();
    do_reset();
    lk_rsp_valid = 1'b1; lk_rsp_pf = 1'b1; lk_rsp_hit = 1'b0; lk_rsp_addr = 32'hABCD00C0;
    @(negedge clk);
    check({31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, 32'hABCD00C0}, "R8 prefetch miss");
    lk_rsp_hit = 1'b1; lk_rsp_addr = 32'h11110040;
    @(negedge clk);
    check({63'd0, mem_req_valid}, 64'd0, "R8 prefetch hit");
    lk_rsp_pf = 1'b0; lk_rsp_hit = 1'b0; lk_rsp_addr = 32'h22220080;
    @(negedge clk);
    check({63'd0, mem_req_valid}, 64'd0, "R8 demand miss");
    lk_rsp_valid = 1'b0;
  endtask

  task automatic t_lru();
    do_reset();
    load_line(26'h1000, 6'h0);
    load_line(26'h2000, 6'h0);
    load_line(26'h3000, 6'h0);
    load_line(26'h4000, 6'h0);
    load_line(26'h1000, 6'h4);   // touch, now most recent
    load_line(26'h5000, 6'h0);   // evicts 0x2000
    load_line(26'h2001, 6'h0);
    idle_expect_none("R9 evicted stream not confirmed");
    load_line(26'h1001, 6'h0);
    idle_expect_pf(26'h1002, "R9 touched stream kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_demand();
    t_up();
    t_down();
    t_continue();
    t_priority();
    t_throttle();
    t_miss();
    t_lru();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule